// File: doc/BRIEF.md
# Reset and Boot Sequencer

This block controls how a small 8-bit processor's external memory interface enters and leaves reset. An external active-low reset request can arrive at any time. If an external write cycle is running when the request arrives, the block lets that write finish first. It then holds the interface in reset for at least a fixed number of main-clock cycles. While reset is held, every memory and I/O strobe is forced inactive and the battery-backed chip select is floated, so a RAM powered from the backup supply stays deselected.

When the reset request has been withdrawn and the minimum interval has passed, the block samples the two boot-mode pins once. It then reports the boot mode, whether fetch starts from bank 0 through chip select 0 and output enable 0, and the bank 0 defaults: bus width, wait states, write protection and watchdog enable. A one-cycle strobe marks the first cycle after reset. A separate power-on reset initialises the sequencer itself and also produces a full reset interval.

Top module: `boot_rst_seq`

## Requirements
- R1: While `wr_busy` is high, a reset request does not take effect: `rst_active` stays 0 and `mem_strb_n` keeps following `core_strb_n` until `wr_busy` goes low.
- R2: With `wr_busy` low, a reset request drives `rst_active` high by the second rising clock edge after `rst_in_n` falls.
- R3: Once `rst_active` rises, it stays high for at least `MIN_CYC` (128) clock cycles, and it stays high for as long as `rst_in_n` is held low.
- R4: While `rst_active` is high, every bit of `mem_strb_n` is 1 and `bcs_oe` is 0 (the battery-backed select is floated).
- R5: While `rst_active` is low, `mem_strb_n` equals `core_strb_n`, `bcs_n` equals `core_bcs_n` and `bcs_oe` is 1.
- R6: `boot_pins` are sampled once per reset, after `rst_in_n` has returned high. `boot_mode[1:0]` then equals `boot_pins[1:0]` from that moment, and later changes on the pins have no effect until the next reset.
- R7: `fetch_cs0` is 1 when the sampled boot mode is 2'b00, and 0 for any other mode.
- R8: After reset, `bus_16b` = 0 (8-bit bus), `wait_st` = 4, `wr_prot` = 1 and `wdt_en` = 1.
- R9: `boot_valid` is high for exactly one cycle, the first cycle in which `rst_active` is low after a reset.
- R10: A low pulse on `rst_in_n` shorter than one clock period is not lost. It produces a full reset, and that reset is deferred if a write is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| por_n | input | 1 | Power-on reset of the sequencer, asynchronous, active low |
| rst_in_n | input | 1 | External reset request, asynchronous, active low |
| wr_busy | input | 1 | High while an external write cycle is in progress |
| core_strb_n | input | NSTB | Memory and I/O strobes from the core, active low |
| core_bcs_n | input | 1 | Battery-backed chip select from the core, active low |
| boot_pins | input | 2 | Boot-mode pins |
| mem_strb_n | output | NSTB | Strobes to the pads, held high during reset |
| bcs_n | output | 1 | Battery-backed chip select data to the pad |
| bcs_oe | output | 1 | Output enable of the battery-backed chip select pad |
| rst_active | output | 1 | High during reset, low otherwise |
| boot_mode | output | 2 | Boot mode sampled after reset |
| fetch_cs0 | output | 1 | Fetch starts from bank 0 on chip select 0 and output enable 0 |
| bus_16b | output | 1 | Bank 0 bus width, 0 = 8-bit |
| wait_st | output | WS_W | Bank 0 wait states |
| wr_prot | output | 1 | Bank 0 write protection |
| wdt_en | output | 1 | Watchdog enable |
| boot_valid | output | 1 | One-cycle pulse on leaving reset |

## Verification
Several properties are checked on every cycle. A request seen during a write never moves the sequencer into reset. A request without a write does. The reset interval never closes before the minimum count. The boot mode holds between loads, and the valid strobe lasts one cycle and only follows reset. Other behaviour can only be shown by the bench scenarios: deferral lengths of several cycles, sub-cycle request pulses, the strobe and float levels at the pads, sampling of the pins only after release, and the bank 0 default values.

// File: rtl/rbs_pkg.sv
`timescale 1ns/1ps
package rbs_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DEFER = 2'd1,
    ST_HOLD  = 2'd2,
    ST_BOOT  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/rbs_rst_sync.sv
`timescale 1ns/1ps
// Reset request synchroniser: asserts asynchronously, releases after STAGES edges.
module rbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic req_n,
  output logic req_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge req_n) begin
    if (!req_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign req_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/rbs_seq_fsm.sv
`timescale 1ns/1ps
module rbs_seq_fsm
  import rbs_pkg::*;
#(
  parameter int MIN_CYC = 128
) (
  input  logic clk,
  input  logic por_n,
  input  logic req_sync_n,
  input  logic wr_busy,
  output logic in_reset,
  output logic boot_load
);
  localparam int CW = (MIN_CYC > 2) ? $clog2(MIN_CYC) : 1;

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_done;
  logic          cnt_en;

  assign cnt_done = (cnt_q == CW'(MIN_CYC - 1));
  assign cnt_en   = (st_q == ST_HOLD) && !cnt_done;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN: begin
        if (!req_sync_n) st_d = wr_busy ? ST_DEFER : ST_HOLD;
      end
      ST_DEFER: begin
        if (!wr_busy) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (cnt_done && req_sync_n) st_d = ST_BOOT;
      end
      ST_BOOT: st_d = ST_RUN;
      default: st_d = ST_HOLD;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (st_q != ST_HOLD) cnt_d = '0;
    else if (cnt_en)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q  <= ST_HOLD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign in_reset  = (st_q == ST_HOLD) || (st_q == ST_BOOT);
  assign boot_load = (st_q == ST_BOOT);

  // R1: a request seen while a write runs never enters reset on that edge
  p_defer_write_r1: assert property (@(posedge clk) disable iff (!por_n)
    ((st_q == ST_RUN || st_q == ST_DEFER) && wr_busy) |=> (st_q != ST_HOLD));

  // R2: request without a write enters reset at once
  p_enter_now_r2: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == ST_RUN && !req_sync_n && !wr_busy) |=> (st_q == ST_HOLD));

  // R3: reset is held while the request is still asserted
  p_hold_req_r3: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == ST_HOLD && !req_sync_n) |=> (st_q == ST_HOLD));
endmodule

// File: rtl/rbs_boot_cfg.sv
`timescale 1ns/1ps
module rbs_boot_cfg #(
  parameter int   WS_W      = 3,
  parameter int   RST_WAIT  = 4,
  parameter logic RST_BUS16 = 1'b0,
  parameter logic RST_WPROT = 1'b1,
  parameter logic RST_WDT   = 1'b1
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            in_reset,
  input  logic            boot_load,
  input  logic [1:0]      boot_pins,
  output logic [1:0]      boot_mode,
  output logic            fetch_cs0,
  output logic            bus_16b,
  output logic [WS_W-1:0] wait_st,
  output logic            wr_prot,
  output logic            wdt_en,
  output logic            boot_valid
);
  logic [1:0]      mode_q, mode_d;
  logic            fetch_q, fetch_d;
  logic            bus_q, bus_d;
  logic [WS_W-1:0] ws_q, ws_d;
  logic            wp_q, wp_d;
  logic            wdt_q, wdt_d;
  logic            vld_q;

  // Mode capture only on the boot cycle
  always_comb begin
    mode_d  = mode_q;
    fetch_d = fetch_q;
    if (boot_load) begin
      mode_d  = boot_pins;
      fetch_d = (boot_pins == 2'b00);
    end
  end

  // Bank 0 defaults reloaded throughout reset
  always_comb begin
    bus_d = bus_q;
    ws_d  = ws_q;
    wp_d  = wp_q;
    wdt_d = wdt_q;
    if (in_reset) begin
      bus_d = RST_BUS16;
      ws_d  = WS_W'(RST_WAIT);
      wp_d  = RST_WPROT;
      wdt_d = RST_WDT;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q  <= 2'b00;
      fetch_q <= 1'b1;
      bus_q   <= RST_BUS16;
      ws_q    <= WS_W'(RST_WAIT);
      wp_q    <= RST_WPROT;
      wdt_q   <= RST_WDT;
      vld_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      fetch_q <= fetch_d;
      bus_q   <= bus_d;
      ws_q    <= ws_d;
      wp_q    <= wp_d;
      wdt_q   <= wdt_d;
      vld_q   <= boot_load;
    end
  end

  assign boot_mode  = mode_q;
  assign fetch_cs0  = fetch_q;
  assign bus_16b    = bus_q;
  assign wait_st    = ws_q;
  assign wr_prot    = wp_q;
  assign wdt_en     = wdt_q;
  assign boot_valid = vld_q;

  // R6: mode changes only through the boot cycle
  p_mode_stable_r6: assert property (@(posedge clk) disable iff (!por_n)
    !boot_load |=> $stable(boot_mode));

  // R9: valid strobe lasts a single cycle
  p_valid_single_r9: assert property (@(posedge clk) disable iff (!por_n)
    boot_valid |=> !boot_valid);
endmodule

// File: rtl/boot_rst_seq.sv
`timescale 1ns/1ps
module boot_rst_seq #(
  parameter int NSTB        = 5,
  parameter int MIN_CYC     = 128,
  parameter int SYNC_STAGES = 2,
  parameter int WS_W        = 3,
  parameter int RST_WAIT    = 4
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_in_n,
  input  logic            wr_busy,
  input  logic [NSTB-1:0] core_strb_n,
  input  logic            core_bcs_n,
  input  logic [1:0]      boot_pins,
  output logic [NSTB-1:0] mem_strb_n,
  output logic            bcs_n,
  output logic            bcs_oe,
  output logic            rst_active,
  output logic [1:0]      boot_mode,
  output logic            fetch_cs0,
  output logic            bus_16b,
  output logic [WS_W-1:0] wait_st,
  output logic            wr_prot,
  output logic            wdt_en,
  output logic            boot_valid
);
  localparam int KW = $clog2(MIN_CYC) + 2;

  logic req_sync_n;
  logic in_reset;
  logic boot_load;

  rbs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .req_n      (rst_in_n),
    .req_sync_n (req_sync_n)
  );

  rbs_seq_fsm #(.MIN_CYC(MIN_CYC)) u_fsm (
    .clk        (clk),
    .por_n      (por_n),
    .req_sync_n (req_sync_n),
    .wr_busy    (wr_busy),
    .in_reset   (in_reset),
    .boot_load  (boot_load)
  );

  rbs_boot_cfg #(.WS_W(WS_W), .RST_WAIT(RST_WAIT)) u_cfg (
    .clk        (clk),
    .por_n      (por_n),
    .in_reset   (in_reset),
    .boot_load  (boot_load),
    .boot_pins  (boot_pins),
    .boot_mode  (boot_mode),
    .fetch_cs0  (fetch_cs0),
    .bus_16b    (bus_16b),
    .wait_st    (wait_st),
    .wr_prot    (wr_prot),
    .wdt_en     (wdt_en),
    .boot_valid (boot_valid)
  );

  // Pad control: strobes forced inactive, battery select floated in reset
  genvar gi;
  generate
    for (gi = 0; gi < NSTB; gi++) begin : g_strb
      assign mem_strb_n[gi] = core_strb_n[gi] | in_reset;
    end
  endgenerate

  assign bcs_n      = core_bcs_n;
  assign bcs_oe     = !in_reset;
  assign rst_active = in_reset;

  // Checker: length of each reset interval
  logic [KW-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                  hi_cnt_q <= '0;
    else if (!rst_active)        hi_cnt_q <= '0;
    else if (!(&hi_cnt_q))       hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  // R3: reset never shorter than the minimum interval
  p_min_len_r3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_active) |-> (hi_cnt_q >= KW'(MIN_CYC)));

  // R9: valid strobe only on the first cycle out of reset
  p_valid_after_r9: assert property (@(posedge clk) disable iff (!por_n)
    boot_valid |-> (!rst_active && $past(rst_active)));
endmodule

// File: tb/boot_rst_seq_tb.sv
`timescale 1ns/1ps
module boot_rst_seq_tb;
  localparam int NSTB = 5;
  localparam int MINC = 128;

  logic            clk;
  logic            por_n;
  logic            rst_in_n;
  logic            wr_busy;
  logic [NSTB-1:0] core_strb_n;
  logic            core_bcs_n;
  logic [1:0]      boot_pins;
  logic [NSTB-1:0] mem_strb_n;
  logic            bcs_n;
  logic            bcs_oe;
  logic            rst_active;
  logic [1:0]      boot_mode;
  logic            fetch_cs0;
  logic            bus_16b;
  logic [2:0]      wait_st;
  logic            wr_prot;
  logic            wdt_en;
  logic            boot_valid;

  int n_chk;
  int n_fail;

  boot_rst_seq u_dut (
    .clk(clk), .por_n(por_n), .rst_in_n(rst_in_n), .wr_busy(wr_busy),
    .core_strb_n(core_strb_n), .core_bcs_n(core_bcs_n), .boot_pins(boot_pins),
    .mem_strb_n(mem_strb_n), .bcs_n(bcs_n), .bcs_oe(bcs_oe),
    .rst_active(rst_active), .boot_mode(boot_mode), .fetch_cs0(fetch_cs0),
    .bus_16b(bus_16b), .wait_st(wait_st), .wr_prot(wr_prot), .wdt_en(wdt_en),
    .boot_valid(boot_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: {busy cycles[7:0], short pulse, hold cycles[7:0], pins[1:0]}
  localparam int VN = 6;
  localparam logic [18:0] VEC [VN] = '{
    {8'd0, 1'b0, 8'd10,  2'b00},
    {8'd6, 1'b0, 8'd20,  2'b01},
    {8'd0, 1'b1, 8'd0,   2'b10},
    {8'd9, 1'b1, 8'd0,   2'b11},
    {8'd3, 1'b0, 8'd200, 2'b00},
    {8'd1, 1'b0, 8'd5,   2'b10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_after(input logic [1:0] pins, input logic [NSTB-1:0] pat);
    chk("R9 boot_valid first cycle", boot_valid, 1);
    chk("R6 boot_mode sampled", boot_mode, pins);
    chk("R7 fetch_cs0", fetch_cs0, (pins == 2'b00));
    chk("R8 bus_16b", bus_16b, 0);
    chk("R8 wait_st", wait_st, 4);
    chk("R8 wr_prot", wr_prot, 1);
    chk("R8 wdt_en", wdt_en, 1);
    chk("R5 strobes follow core", mem_strb_n, pat);
    chk("R5 bcs_oe", bcs_oe, 1);
    chk("R5 bcs_n follows", bcs_n, core_bcs_n);
    @(negedge clk);
    chk("R9 boot_valid one cycle", boot_valid, 0);
    boot_pins = ~pins;
    repeat (4) @(negedge clk);
    chk("R6 pins ignored after boot", boot_mode, pins);
    chk("R6 rst_active low", rst_active, 0);
  endtask

  task automatic run_seq(input int busy, input bit short_p, input int hold,
                         input logic [1:0] pins, input logic [NSTB-1:0] pat);
    int waited;
    int hi;
    int guard;
    @(negedge clk);
    core_strb_n = pat;
    core_bcs_n  = pat[0];
    boot_pins   = ~pins;
    wr_busy     = (busy != 0);
    rst_in_n    = 1'b0;
    if (short_p) begin
      #2 rst_in_n = 1'b1;
    end
    for (int i = 0; i < busy; i++) begin
      @(negedge clk);
      chk("R1 no reset during write", rst_active, 0);
      chk("R1 strobes follow during write", mem_strb_n, pat);
    end
    wr_busy = 1'b0;
    waited = 0;
    while (!rst_active && waited < 4) begin
      @(negedge clk);
      waited++;
    end
    chk("R2 R10 reset entered", rst_active, 1);
    chk("R2 entry latency", (waited <= 2), 1);
    if (short_p) boot_pins = pins;
    hi = 1;
    guard = 0;
    while (rst_active && guard < 1000) begin
      if (hi == 5) begin
        chk("R4 strobes high", mem_strb_n, {NSTB{1'b1}});
        chk("R4 bcs floated", bcs_oe, 0);
      end
      if (!short_p && hi == hold) begin
        rst_in_n  = 1'b1;
        boot_pins = pins;
      end
      @(negedge clk);
      if (rst_active) hi++;
      guard++;
    end
    chk("R3 minimum length", (hi >= MINC), 1);
    if (hold > MINC) chk("R3 held while request low", (hi >= hold), 1);
    check_after(pins, pat);
  endtask

  initial begin
    int hi;
    n_chk = 0;
    n_fail = 0;
    por_n = 1'b0;
    rst_in_n = 1'b0;
    wr_busy = 1'b0;
    core_strb_n = 5'b10101;
    core_bcs_n = 1'b0;
    boot_pins = 2'b00;
    repeat (3) @(negedge clk);
    chk("R4 reset state rst_active", rst_active, 1);
    chk("R4 reset state strobes high", mem_strb_n, 5'b11111);
    chk("R4 reset state bcs floated", bcs_oe, 0);
    por_n = 1'b1;
    rst_in_n = 1'b1;
    hi = 1;
    for (int g = 0; g < 1000 && rst_active; g++) begin
      @(negedge clk);
      if (rst_active) hi++;
    end
    chk("R3 power-on length", (hi >= MINC), 1);
    check_after(2'b00, 5'b10101);

    for (int v = 0; v < VN; v++) begin
      run_seq(int'(VEC[v][18:11]), VEC[v][10], int'(VEC[v][9:2]), VEC[v][1:0],
              NSTB'(5'b00011 + v * 7));
    end

    // Request pulse starting and ending within one long write (R10, R1)
    run_seq(12, 1'b1, 0, 2'b01, 5'b01110);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule